// File: doc/BRIEF.md
# Selection Timeout Timer with Clock-Range Prescaler

This block times one selection or reselection attempt on a parallel peripheral bus. Software programs two settings through a small write port. The first is an 8-bit timeout count. The second is a 3-bit clock-range code that gives the conversion factor. A prescaler divides the input clock into ticks, each `TICK_BASE` (8192 by default) times the factor input clocks long. The countdown runs in these ticks.

The selection sequencer starts an attempt with a one-cycle start pulse. The timer then loads the programmed count and restarts its prescaler from zero. It counts down one step per tick. When the count runs out, it raises a one-cycle timeout pulse and goes back to idle. If the sequencer reports that the target answered before that, the attempt is cancelled and no pulse appears. A new start pulse restarts the attempt at any time.

The controller has three named states:
- IDLE waits for a start.
- COUNT runs the countdown.
- FIRE lasts one cycle and drives the timeout pulse.

The transitions are:
- start: any state to COUNT.
- respond: COUNT to IDLE.
- expire: COUNT to FIRE.
- done: FIRE to IDLE.

Top module: `sel_timeout_timer`

## Requirements
- R1: After reset, `timeout_o` and `cfg_err_o` are low, and no timeout pulse appears while no start has been given.
- R2: A write with `cfg_wr_en`=1 and `cfg_sel`=0 stores `cfg_wdata` as the timeout count. A write with `cfg_sel`=1 stores `cfg_wdata[2:0]` as the clock-range code.
- R3: Clock-range codes 2 to 7 give a factor equal to the code. Code 0 gives a factor of 8.
- R4: With count N (1..255) and factor F, `timeout_o` is high in the cycle that follows the clock edge N·TICK_BASE·F cycles after the edge that captured `start_i`.
- R5: A count of 0 is taken as 256 ticks.
- R6: The timeout pulse is exactly one cycle wide. No further pulse follows until the next start.
- R7: `resp_seen_i` high during a countdown without `start_i` cancels the attempt, and no timeout pulse follows.
- R8: A start pulse during a countdown restarts both the count and the prescaler, so the timeout is measured from the new start alone.
- R9: Code 1 is invalid. It runs with a factor of 2 and sets `cfg_err_o` one cycle after the write. The flag then stays set until reset.
- R10: Configuration writes during a countdown do not change the timing of the attempt already running. Count and factor are captured at start.
- R11: When `start_i` and `resp_seen_i` are high in the same cycle, the start wins and a countdown begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the timeout count, 1 selects the clock-range code |
| cfg_wdata | input | CNT_W | Write data |
| start_i | input | 1 | One-cycle start of a selection attempt |
| resp_seen_i | input | 1 | Target answered; cancels the countdown |
| timeout_o | output | 1 | One-cycle timeout pulse |
| cfg_err_o | output | 1 | Sticky flag: the invalid clock-range code was written |

## Verification
The countdown is exercised with several count and code pairs: codes 2, 5, 7 and 0, and count 0 paired with code 3. An exact cycle count per pair separates a wrong factor mapping from an off-by-one in the tick or count logic, and the 256-tick wrap is checked on its own.

Cancel and restart are each placed partway through a prescaler period. Only an attempt that is truly cancelled stays silent, and only a prescaler that is cleared on start hits the expected cycle after the restart.

Mid-count writes, a start and a response in the same cycle, and the invalid code each have a directed scenario. Together they separate values captured at start from live register values, check the priority order, and check that the error flag is sticky.

// File: rtl/sel_tmo_pkg.sv
package sel_tmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } tmo_state_e;

    localparam int CODE_W     = 3;
    localparam int FACTOR_W   = 4;
    localparam int MAX_FACTOR = 8;

    // Clock-range code to division factor; code 1 is invalid and runs as 2
    function automatic logic [FACTOR_W-1:0] code_to_factor(input logic [CODE_W-1:0] code);
        logic [FACTOR_W-1:0] f;
        unique case (code)
            3'd0:    f = 4'd8;
            3'd1:    f = 4'd2;
            default: f = {1'b0, code};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sel_tmo_cfg.sv
module sel_tmo_cfg
    import sel_tmo_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     count_q,
    output logic [CODE_W-1:0]    code_q,
    output logic                 cfg_err_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            code_q    <= '0;
            cfg_err_o <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                count_q <= wr_data;
            end else begin
                code_q <= wr_data[CODE_W-1:0];
                if (wr_data[CODE_W-1:0] == CODE_W'(1)) begin
                    cfg_err_o <= 1'b1;
                end
            end
        end
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cfg_err_o));

    // R9
    err_on_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[CODE_W-1:0] == CODE_W'(1)) |=> cfg_err_o);

endmodule

// File: rtl/sel_tmo_prescaler.sv
module sel_tmo_prescaler
    import sel_tmo_pkg::*;
#(
    parameter int TICK_BASE = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic [FACTOR_W-1:0]  factor_i,
    output logic                 tick_o
);

    localparam int LIM_MAX = TICK_BASE * MAX_FACTOR;
    localparam int PW      = $clog2(LIM_MAX + 1);

    logic [PW-1:0] div_q;
    logic [PW-1:0] limit_q;

    assign tick_o = en_i && (div_q == limit_q - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            limit_q <= PW'(TICK_BASE) * PW'(2);
        end else if (clr_i) begin
            div_q   <= '0;
            limit_q <= PW'(TICK_BASE) * PW'(factor_i);
        end else if (en_i) begin
            div_q <= tick_o ? '0 : div_q + PW'(1);
        end
    end

    // R4
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R8
    clr_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_o);

endmodule

// File: rtl/sel_tmo_fsm.sv
module sel_tmo_fsm
    import sel_tmo_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 resp_i,
    input  logic                 tick_i,
    input  logic [CNT_W-1:0]     load_val_i,
    output logic                 presc_clr_o,
    output logic                 presc_en_o,
    output logic                 timeout_o
);

    localparam int RW = CNT_W + 1;

    tmo_state_e    state_q, state_d;
    logic [RW-1:0] rem_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_COUNT: begin
                    if (resp_i)
                        state_d = ST_IDLE;
                    else if (tick_i && rem_q == RW'(1))
                        state_d = ST_FIRE;
                end
                ST_FIRE:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // remaining ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (start_i) begin
            rem_q <= (load_val_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val_i};
        end else if (state_q == ST_COUNT && tick_i && !resp_i) begin
            rem_q <= rem_q - RW'(1);
        end
    end

    // outputs
    always_comb begin
        presc_clr_o = start_i;
        presc_en_o  = (state_q == ST_COUNT);
        timeout_o   = (state_q == ST_FIRE);
    end

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    // R7
    resp_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_i && !start_i) |=> !timeout_o);

    // R11
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_COUNT));

    // R5
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (rem_q != '0));

endmodule

// File: rtl/sel_timeout_timer.sv
module sel_timeout_timer
    import sel_tmo_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TICK_BASE = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             start_i,
    input  logic             resp_seen_i,
    output logic             timeout_o,
    output logic             cfg_err_o
);

    logic [CNT_W-1:0]    count_q;
    logic [CODE_W-1:0]   code_q;
    logic [FACTOR_W-1:0] factor;
    logic                presc_clr, presc_en, tick;

    assign factor = code_to_factor(code_q);

    sel_tmo_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .count_q   (count_q),
        .code_q    (code_q),
        .cfg_err_o (cfg_err_o)
    );

    sel_tmo_prescaler #(.TICK_BASE(TICK_BASE)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (presc_clr),
        .en_i     (presc_en),
        .factor_i (factor),
        .tick_o   (tick)
    );

    sel_tmo_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .resp_i      (resp_seen_i),
        .tick_i      (tick),
        .load_val_i  (count_q),
        .presc_clr_o (presc_clr),
        .presc_en_o  (presc_en),
        .timeout_o   (timeout_o)
    );

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!presc_en && !start_i) |=> !tick);

endmodule

// File: tb/sim_sel_timeout_timer.sv
`timescale 1ns/1ps
module sim_sel_timeout_timer;

    localparam int TB_BASE = 4;
    localparam int CW      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          start_i = 1'b0;
    logic          resp_seen_i = 1'b0;
    logic          timeout_o, cfg_err_o;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    always #5 clk = ~clk;

    sel_timeout_timer #(.CNT_W(CW), .TICK_BASE(TB_BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start_i(start_i), .resp_seen_i(resp_seen_i),
        .timeout_o(timeout_o), .cfg_err_o(cfg_err_o)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input bit sel, input int data);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = CW'(data);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_start(input bit with_resp);
        start_i = 1'b1; resp_seen_i = with_resp;
        @(negedge clk);
        start_i = 1'b0; resp_seen_i = 1'b0;
    endtask

    // k0 cycles already elapsed since start capture; expects pulse at exp
    task automatic measure(input int k0, input int exp, input string tag);
        int k = k0;
        bit seen = 0;
        while (k < exp + 50) begin
            @(negedge clk);
            k++;
            if (timeout_o) begin seen = 1; break; end
        end
        chk(seen && k == exp, tag, seen ? k : -1, exp);
        @(negedge clk);
        chk(!timeout_o, "R6 pulse width", int'(timeout_o), 0);
    endtask

    task automatic quiet(input int n, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (timeout_o) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    task automatic t_reset();
        chk(!timeout_o, "R1 timeout after reset", int'(timeout_o), 0);
        chk(!cfg_err_o, "R1 cfg_err after reset", int'(cfg_err_o), 0);
        quiet(60, "R1 no pulse without start");
    endtask

    task automatic t_basic(input int n, input int code, input int f, input string tag);
        wr_cfg(0, n);
        wr_cfg(1, code);
        do_start(0);
        measure(0, (n == 0 ? 256 : n) * TB_BASE * f, tag);
        quiet(40, "R6 no second pulse");
    endtask

    task automatic t_cancel();
        wr_cfg(0, 4); wr_cfg(1, 2);
        do_start(0);
        repeat (21) @(negedge clk);
        resp_seen_i = 1'b1;
        @(negedge clk);
        resp_seen_i = 1'b0;
        quiet(80, "R7 cancel suppresses pulse");
    endtask

    task automatic t_restart();
        wr_cfg(0, 4); wr_cfg(1, 2);
        do_start(0);
        repeat (13) @(negedge clk);
        chk(!timeout_o, "R8 no early pulse", int'(timeout_o), 0);
        do_start(0);
        measure(0, 32, "R8 restart timing");
    endtask

    task automatic t_midwrite();
        wr_cfg(0, 2); wr_cfg(1, 2);
        do_start(0);
        repeat (5) @(negedge clk);
        wr_cfg(0, 9);
        wr_cfg(1, 7);
        measure(7, 16, "R10 mid-count write ignored");
        do_start(0);
        measure(0, 9 * TB_BASE * 7, "R2 new config used next start");
    endtask

    task automatic t_same_cycle();
        wr_cfg(0, 3); wr_cfg(1, 2);
        do_start(1);
        measure(0, 24, "R11 start beats resp");
    endtask

    task automatic t_bad_code();
        chk(!cfg_err_o, "R9 flag clear before", int'(cfg_err_o), 0);
        wr_cfg(0, 3);
        wr_cfg(1, 1);
        chk(cfg_err_o, "R9 flag set", int'(cfg_err_o), 1);
        do_start(0);
        measure(0, 24, "R9 code 1 runs as factor 2");
        wr_cfg(1, 4);
        chk(cfg_err_o, "R9 flag sticky", int'(cfg_err_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cfg_err_o, "R9 reset clears flag", int'(cfg_err_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(3, 2, 2, "R4 count3 code2");
        t_basic(2, 5, 5, "R3 count2 code5");
        t_basic(1, 7, 7, "R3 count1 code7");
        t_basic(2, 0, 8, "R3 code0 factor8");
        t_basic(0, 3, 3, "R5 count0 is 256");
        t_cancel();
        t_restart();
        t_midwrite();
        t_same_cycle();
        t_bad_code();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule